// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This block moves received frames from a MAC-side byte stream into host memory. Incoming bytes go into a store-and-forward FIFO. A frame becomes visible to the DMA side only once its final byte has arrived. When a complete frame is waiting and the engine is running, it reads the current descriptor from memory. A descriptor is four 32-bit words: a status word at offset 0, a buffer-size word at offset 4, a buffer address at offset 8 and a next-descriptor pointer at offset 12. The engine then copies the frame into the buffer and writes the stored length back into the status word. Writing the status word with the ownership bit clear hands the descriptor back to software, and the engine then follows the next pointer.

Software builds the ring, usually with the last descriptor pointing back to the first, and places the ring start on `ring_base`. It then pulses `rx_start`. If a fetched descriptor is still owned by software, the engine stops without touching it. It reads that same descriptor again after the next start pulse. Frames that arrive while the FIFO has no room are discarded whole. A frame longer than its buffer is cut at the buffer size.

Top module: `rxd_dma`

## Requirements
- R1: While reset is held and right after it, `mem_req`, `dma_running` and `frame_done` are all 0.
- R2: The first `rx_start` pulse after reset loads the descriptor pointer from `ring_base`, so the first memory access is a read of `ring_base`. Later start pulses leave the pointer unchanged.
- R3: For each frame the engine reads the descriptor words in the order status (+0), size (+4), buffer (+8) and next (+12). It reads the size from bits [13:0] of the size word.
- R4: If the status word read has bit 31 clear, the engine makes no further memory access and clears `dma_running`. Pending frames stay queued. The next `rx_start` re-reads the same descriptor.
- R5: Frame byte k is written to buffer address + k, in byte lane k mod 4 of a 32-bit little-endian word. Words are written in ascending order. Byte enables are set only for lanes that hold frame bytes, so memory past the stored length is untouched.
- R6: After the data, the engine writes the descriptor status word with enables 4'hF and value (stored length << 16), 14-bit length in bits [29:16], bits 31 and 30 clear. `frame_done` pulses for one cycle in the cycle after that write is acknowledged.
- R7: No descriptor read starts while the FIFO holds only part of a frame. Moving a frame begins only after its last byte (`rx_last`) has been accepted.
- R8: A frame longer than the descriptor's buffer size stores only buffer-size bytes and reports that length. The rest of the frame is discarded, and the following frame is unaffected.
- R9: A frame whose bytes do not fit in the FIFO (FIFO_DEPTH bytes) is dropped entirely. Frames already queued and frames arriving later are kept.
- R10: After each completed frame, the next descriptor comes from the next-pointer word, so a ring that points back to its first entry wraps.
- R11: A memory request, once raised, stays high with stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_start | input | 1 | Start pulse: set the running bit (re-poll after a stall) |
| ring_base | input | ADDR_W | Address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_ack | input | 1 | Access completes in this cycle (read data valid) |
| mem_rdata | input | 32 | Read data |
| dma_running | output | 1 | Engine is running |
| frame_done | output | 1 | One-cycle pulse per frame handed back |

## Verification
Memory latency in the bench is random, so the due cycle of each frame's result is set by the handshake. The status write-back lands at the acknowledge, and `frame_done` follows in the next cycle. The bench therefore waits on the `frame_done` pulses, with a bounded cycle count, and only then reads buffer and status contents from its memory model. Stall and drop results carry no pulse, so the bench checks them after fixed idle windows of tens of cycles. Request holding and the partial-frame window are sampled every cycle, one time unit after the falling edge, when the acknowledge for the next rising edge is already settled.

// File: rtl/rxd_pkg.sv
// Shared definitions of the receive descriptor DMA.
// Assumes 32-bit descriptor words; the length field position is fixed
// because software decodes it.
package rxd_pkg;
    localparam int LEN_W     = 14;
    localparam int OWN_BIT   = 31;
    localparam int WORD_BYTES = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_SIZE,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_MOVE,
        ST_WR_DATA,
        ST_DRAIN,
        ST_WR_STAT
    } eng_state_e;
endpackage

// File: rtl/rxd_frame_fifo.sv
// Store-and-forward byte FIFO. Each entry holds a byte and its end flag.
// Bytes become readable only once their frame is complete (commit pointer).
// A frame that meets a full FIFO is rewound and its remaining bytes ignored.
// Assumes the reader pops only while head_valid is high.
module rxd_frame_fifo #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       pop,
    output logic [7:0] head_data,
    output logic       head_last,
    output logic       head_valid,
    output logic       frame_avail
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [8:0]    store [DEPTH];
    logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr, frames, used;
    logic          dropping, full, accept, commit, pop_last;

    assign used     = wr_ptr - rd_ptr;
    assign full     = (used == PW'(DEPTH));
    assign accept   = in_valid && !dropping && !full;
    assign commit   = accept && in_last;
    assign pop_last = pop && head_last;

    assign head_valid  = (rd_ptr != cmt_ptr);
    assign frame_avail = (frames != '0);
    assign head_data   = store[rd_ptr[AW-1:0]][7:0];
    assign head_last   = store[rd_ptr[AW-1:0]][8];

    // Byte storage write
    always_ff @(posedge clk) begin
        if (accept) store[wr_ptr[AW-1:0]] <= {in_last, in_data};
    end

    // Pointer, drop and frame-count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            cmt_ptr  <= '0;
            rd_ptr   <= '0;
            frames   <= '0;
            dropping <= 1'b0;
        end else begin
            if (in_valid) begin
                if (dropping) begin
                    if (in_last) dropping <= 1'b0;
                end else if (full) begin
                    wr_ptr   <= cmt_ptr;
                    dropping <= !in_last;
                end else begin
                    wr_ptr <= wr_ptr + PW'(1);
                    if (in_last) cmt_ptr <= wr_ptr + PW'(1);
                end
            end
            if (pop) rd_ptr <= rd_ptr + PW'(1);
            frames <= frames + PW'(commit) - PW'(pop_last);
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));
    // R7
    pop_committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/rxd_desc_engine.sv
// Descriptor engine: fetches the four descriptor words, checks ownership,
// packs FIFO bytes into little-endian words, writes them to the buffer,
// writes the length back and follows the next pointer.
// Assumes a frame is wholly present in the FIFO when frame_avail is set,
// and memory completes one access per mem_ack with read data in that cycle.
module rxd_desc_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              frame_avail,
    input  logic              head_valid,
    input  logic [7:0]        head_data,
    input  logic              head_last,
    output logic              pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              running,
    output logic              frame_done
);
    eng_state_e        state;
    logic              ptr_loaded, fin_q, drain_q;
    logic [ADDR_W-1:0] desc_ptr, next_q, waddr;
    logic [LEN_W-1:0]  size_q, cnt, cnt_nx;
    logic [31:0]       word_q;
    logic [3:0]        be_q;
    logic [1:0]        lane;
    logic              end_w;

    assign lane   = cnt[1:0];
    assign cnt_nx = cnt + LEN_W'(1);
    assign end_w  = head_last || (cnt_nx == size_q);

    // Memory request and FIFO pop decode per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_wdata = word_q;
        mem_be    = 4'hF;
        pop       = 1'b0;
        unique case (state)
            ST_RD_STAT: mem_req = 1'b1;
            ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(WORD_BYTES);   end
            ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(2*WORD_BYTES); end
            ST_RD_NEXT: begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(3*WORD_BYTES); end
            ST_MOVE:    pop = head_valid && (cnt != size_q);
            ST_WR_DATA: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = waddr;
                mem_be   = be_q;
            end
            ST_DRAIN:   pop = head_valid;
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {2'b00, cnt, 16'h0000};
            end
            default: ;
        endcase
    end

    // Sequencer: descriptor walk, byte packing and write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            running    <= 1'b0;
            ptr_loaded <= 1'b0;
            desc_ptr   <= '0;
            next_q     <= '0;
            waddr      <= '0;
            size_q     <= '0;
            cnt        <= '0;
            word_q     <= '0;
            be_q       <= '0;
            fin_q      <= 1'b0;
            drain_q    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (running && frame_avail) state <= ST_RD_STAT;
                ST_RD_STAT: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) state <= ST_RD_SIZE;
                    else begin
                        running <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                ST_RD_SIZE: if (mem_ack) begin
                    size_q <= mem_rdata[LEN_W-1:0];
                    state  <= ST_RD_BUF;
                end
                ST_RD_BUF: if (mem_ack) begin
                    waddr  <= mem_rdata[ADDR_W-1:0];
                    cnt    <= '0;
                    word_q <= '0;
                    be_q   <= '0;
                    state  <= ST_RD_NEXT;
                end
                ST_RD_NEXT: if (mem_ack) begin
                    next_q <= mem_rdata[ADDR_W-1:0];
                    state  <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (cnt == size_q) state <= ST_DRAIN;
                    else if (head_valid) begin
                        word_q[{lane, 3'b000} +: 8] <= head_data;
                        be_q[lane] <= 1'b1;
                        cnt        <= cnt_nx;
                        fin_q      <= end_w;
                        drain_q    <= end_w && !head_last;
                        if (lane == 2'd3 || end_w) state <= ST_WR_DATA;
                    end
                end
                ST_WR_DATA: if (mem_ack) begin
                    waddr  <= waddr + ADDR_W'(WORD_BYTES);
                    word_q <= '0;
                    be_q   <= '0;
                    if (!fin_q)       state <= ST_MOVE;
                    else if (drain_q) state <= ST_DRAIN;
                    else              state <= ST_WR_STAT;
                end
                ST_DRAIN: if (head_valid && head_last) state <= ST_WR_STAT;
                ST_WR_STAT: if (mem_ack) begin
                    desc_ptr   <= next_q;
                    frame_done <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (start) begin
                running    <= 1'b1;
                ptr_loaded <= 1'b1;
                if (!ptr_loaded) desc_ptr <= base_addr;
            end
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R5
    wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));
    // R7
    fetch_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_STAT) |-> frame_avail);
    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_STAT) |-> (cnt <= size_q));
    // R6
    done_after_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(state == ST_WR_STAT && mem_ack));
endmodule

// File: rtl/rxd_dma.sv
// Receive descriptor ring DMA top: store-and-forward FIFO feeding the
// descriptor engine, which drives a simple request/acknowledge memory port.
// Assumes ring_base is stable before the first rx_start pulse.
module rxd_dma #(
    parameter int FIFO_DEPTH = 64,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_start,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              dma_running,
    output logic              frame_done
);
    logic       pop, head_valid, head_last, frame_avail;
    logic [7:0] head_data;

    rxd_frame_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_last    (rx_last),
        .pop        (pop),
        .head_data  (head_data),
        .head_last  (head_last),
        .head_valid (head_valid),
        .frame_avail(frame_avail)
    );

    rxd_desc_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rx_start),
        .base_addr  (ring_base),
        .frame_avail(frame_avail),
        .head_valid (head_valid),
        .head_data  (head_data),
        .head_last  (head_last),
        .pop        (pop),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .running    (dma_running),
        .frame_done (frame_done)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !dma_running && !frame_done));
endmodule

// File: tb/rxd_dma_tb.sv
// Bench: random-latency memory model, random frames with directed corners.
module rxd_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NDESC      = 4;
    localparam logic [31:0] BASE = 32'h40;
    localparam logic [31:0] BUFB = 32'h100;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_start = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        mem_req, mem_we, mem_ack, dma_running, frame_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mm [0:1023];
    logic [7:0]  exp_data [0:15][0:63];
    logic [31:0] rlog [$];
    int total = 0, fails = 0, done_cnt = 0, sf_viol = 0, hold_viol = 0;
    bit partial_win = 1'b0, prev_req = 1'b0, prev_ack = 1'b0, summed = 1'b0;
    logic [31:0] prev_addr = '0;

    rxd_dma u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_start(rx_start), .ring_base(BASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dma_running(dma_running), .frame_done(frame_done)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Memory responder with random acknowledge delay
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && ($urandom % 3) != 0) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mm[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata = mm[mem_addr[11:2]];
                    rlog.push_back(mem_addr);
                end
            end else mem_ack = 1'b0;
        end
    end

    // Per-cycle monitor: done pulses, partial-frame window, request holding
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (frame_done) done_cnt++;
            if (partial_win && mem_req) sf_viol++;
            if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) hold_viol++;
        end
        prev_req = mem_req;
        prev_ack = mem_ack;
        prev_addr = mem_addr;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(int a);
        return mm[a/4][8*(a%4) +: 8];
    endfunction

    function automatic logic [31:0] exp_status(int len);
        return {2'b00, 14'(len), 16'h0000};
    endfunction

    task automatic setup_desc(int i, bit own, int size);
        int a = int'(BASE) + 16*i;
        mm[a/4]     = own ? 32'h8000_0000 : 32'h0;
        mm[a/4 + 1] = 32'(size);
        mm[a/4 + 2] = BUFB + 32'(i*128);
        mm[a/4 + 3] = BASE + 32'(16*((i+1) % NDESC));
        for (int w = 0; w < 32; w++) mm[(int'(BUFB) + i*128)/4 + w] = 32'hEEEE_EEEE;
    endtask

    task automatic gen_frame(int fi, int len);
        for (int k = 0; k < len; k++) exp_data[fi][k] = 8'($urandom);
    endtask

    task automatic send_frame(int fi, int len, int gap, bit sf);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (sf && k == len-1) partial_win = 1'b0;
            rx_valid = 1'b1;
            rx_data  = exp_data[fi][k];
            rx_last  = (k == len-1);
            if (gap > 0 && k != len-1) begin
                @(negedge clk);
                rx_valid = 1'b0;
                repeat (gap-1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic wait_done(int target, string req);
        int w = 0;
        while (done_cnt < target && w < 3000) begin @(negedge clk); w++; end
        chk(req, "frame_done count", 32'(done_cnt), 32'(target));
    endtask

    task automatic check_frame(int di, int fi, int wlen, string ctx);
        int b = int'(BUFB) + di*128;
        int bad = 0, tail = 0;
        for (int k = 0; k < wlen; k++) if (mbyte(b+k) !== exp_data[fi][k]) bad++;
        for (int k = wlen; k < wlen+8; k++) if (mbyte(b+k) !== 8'hEE) tail++;
        chk("R5", {ctx, " bad data bytes"}, 32'(bad), 0);
        chk("R5", {ctx, " touched bytes past length"}, 32'(tail), 0);
        chk("R6", {ctx, " status word"}, mm[(int'(BASE) + 16*di)/4], exp_status(wlen));
    endtask

    task automatic finish_run();
        if (!summed) begin
            summed = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int fid = 0, di = 0, dn = 0, len = 0;
        void'($urandom(32'd5150));
        for (int i = 0; i < 1024; i++) mm[i] = '0;
        repeat (4) @(negedge clk);
        // R1: quiet during reset
        chk("R1", "mem_req in reset", 32'(mem_req), 0);
        chk("R1", "running in reset", 32'(dma_running), 0);
        chk("R1", "frame_done in reset", 32'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_req after reset", 32'(mem_req), 0);

        // R4: not-owned descriptor stalls, restart re-polls it
        for (int i = 0; i < NDESC; i++) setup_desc(i, i != 0, 2044);
        gen_frame(fid, 12);
        send_frame(fid, 12, 0, 1'b0);
        kick();
        repeat (60) @(negedge clk);
        chk("R4", "done while not owned", 32'(done_cnt), 0);
        chk("R4", "running after stall", 32'(dma_running), 0);
        chk("R4", "reads during stall", 32'(rlog.size()), 1);
        chk("R2", "first read address", rlog.size() > 0 ? rlog[0] : 32'hFFFF_FFFF, BASE);
        rlog.delete();
        mm[BASE/4] = 32'h8000_0000;
        dn = 1;
        kick();
        wait_done(dn, "R4");
        for (int k = 0; k < 4; k++)
            chk("R3", "descriptor read order", rlog.size() > k ? rlog[k] : 32'hFFFF_FFFF,
                BASE + 32'(4*k));
        check_frame(0, fid, 12, "repoll");
        chk("R2", "running after restart", 32'(dma_running), 1);
        fid++;
        di = 1;

        // R10: single frames walking and wrapping the ring, random lengths
        for (int n = 0; n < 7; n++) begin
            len = (n == 0) ? 4 : (n == 1) ? 5 : 1 + int'($urandom % 40);
            setup_desc(di, 1'b1, 2044);
            gen_frame(fid % 16, len);
            send_frame(fid % 16, len, int'($urandom % 2), 1'b0);
            dn++;
            wait_done(dn, "R10");
            check_frame(di, fid % 16, len, "ring walk");
            fid++;
            di = (di + 1) % NDESC;
        end

        // R5: back-to-back burst of three frames
        begin
            int lens [3];
            int fids [3];
            for (int i = 0; i < NDESC; i++) setup_desc(i, 1'b1, 2044);
            for (int j = 0; j < 3; j++) begin
                lens[j] = 1 + int'($urandom % 18);
                fids[j] = fid % 16;
                gen_frame(fids[j], lens[j]);
                fid++;
            end
            for (int j = 0; j < 3; j++) send_frame(fids[j], lens[j], 0, 1'b0);
            dn += 3;
            wait_done(dn, "R5");
            for (int j = 0; j < 3; j++) check_frame((di + j) % NDESC, fids[j], lens[j], "burst");
            di = (di + 3) % NDESC;
        end

        // R8: truncation to buffer size, next frame clean
        setup_desc(di, 1'b1, 10);
        gen_frame(fid % 16, 17);
        send_frame(fid % 16, 17, 0, 1'b0);
        dn++;
        wait_done(dn, "R8");
        chk("R8", "truncated status", mm[(int'(BASE) + 16*di)/4], exp_status(10));
        check_frame(di, fid % 16, 10, "truncated");
        fid++;
        di = (di + 1) % NDESC;
        setup_desc(di, 1'b1, 2044);
        gen_frame(fid % 16, 6);
        send_frame(fid % 16, 6, 0, 1'b0);
        dn++;
        wait_done(dn, "R8");
        check_frame(di, fid % 16, 6, "after truncation");
        fid++;
        di = (di + 1) % NDESC;

        // R7: no fetch while only part of a frame is in the FIFO
        setup_desc(di, 1'b1, 2044);
        gen_frame(fid % 16, 9);
        partial_win = 1'b1;
        send_frame(fid % 16, 9, 3, 1'b1);
        dn++;
        wait_done(dn, "R7");
        chk("R7", "requests during partial frame", 32'(sf_viol), 0);
        check_frame(di, fid % 16, 9, "slow frame");
        fid++;
        di = (di + 1) % NDESC;

        // R9: overflowing frame dropped while engine is stalled
        begin
            int fa, fb, fc, d1;
            d1 = (di + 1) % NDESC;
            setup_desc(di, 1'b0, 2044);
            setup_desc(d1, 1'b1, 2044);
            fa = fid % 16; fb = (fid + 1) % 16; fc = (fid + 2) % 16;
            gen_frame(fa, 40); gen_frame(fb, 40); gen_frame(fc, 10);
            send_frame(fa, 40, 0, 1'b0);
            repeat (20) @(negedge clk);
            send_frame(fb, 40, 0, 1'b0);
            send_frame(fc, 10, 0, 1'b0);
            chk("R9", "running while stalled", 32'(dma_running), 0);
            mm[(int'(BASE) + 16*di)/4] = 32'h8000_0000;
            kick();
            dn += 2;
            wait_done(dn, "R9");
            repeat (100) @(negedge clk);
            chk("R9", "no extra frame", 32'(done_cnt), 32'(dn));
            check_frame(di, fa, 40, "kept before drop");
            check_frame(d1, fc, 10, "kept after drop");
        end

        chk("R11", "request changed before ack", 32'(hold_viol), 0);
        finish_run();
    end
endmodule